// File: doc/BRIEF.md
# Packed Float-to-Int64 Truncating Converter

This block turns up to eight IEEE-754 single-precision values into signed 64-bit integers, rounding every value toward zero. Each 32-bit source element widens into a 64-bit result lane. A vector-length select sets how many lanes take part: two, four or eight. Result bits above the selected length are cleared.

A per-lane writemask picks which lanes receive a converted value. The mask can be switched off as a whole. A masked-off lane either keeps the matching lane of a supplied prior destination or is forced to zero. A broadcast option feeds source element 0 to every lane. Values that do not fit in a signed 64-bit integer give the integer-indefinite pattern and raise an invalid flag. Conversions that drop fraction bits raise a precision flag. A 4-bit reserved specifier field that is not all ones raises an undefined-encoding flag.

The block has a single register stage. Inputs presented before a rising clock edge appear at the outputs after that edge, and the outputs hold until the next edge.

Top module: `f2qConvTop`

## Requirements
- R1: A finite source value converts to its integer part, rounded toward zero. For example, 1.5 gives 1 and -2.75 gives -2. The precision flag rises when any active lane drops nonzero fraction bits.
- R2: `vlSel` sets the lane count: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), 2 gives 8 lanes (512 bits), and 3 also gives 8 lanes. Result lane j occupies bits 64j+63..64j and is converted from source bits 32j+31..32j.
- R3: A lane within the vector length is active when `maskEn` is 0, or when `maskEn` is 1 and `laneMask[j]` is 1. An active lane receives the converted value.
- R4: When `zeroMode` is 0 (merging), an inactive lane within the vector length outputs `priorDst` bits 64j+63..64j unchanged.
- R5: When `zeroMode` is 1 (zeroing), an inactive lane within the vector length outputs zero.
- R6: When `bcastEn` is 1, every active lane converts source bits 31..0 instead of its own element.
- R7: All result bits from the selected vector length up to bit 511 are zero, whatever the mask, mode and prior value.
- R8: NaN, either infinity, or a finite magnitude of 2^63 or more gives 0x8000_0000_0000_0000 in an active lane and raises the invalid flag. The one exception is exactly -2^63, which converts to the same pattern without raising invalid.
- R9: `undefFlag` is 1 exactly when `resvField` differs from 4'b1111. The result and the other flags are still produced as usual.
- R10: The invalid and precision flags are the OR over the active lanes of the current operation only. Inactive lanes and lanes above the vector length never raise a flag.
- R11: Zeros of either sign and denormal inputs convert to 0. A nonzero denormal raises precision; a zero raises no flag.
- R12: While `rstN` is low, all outputs are zero. After reset, each output reflects the inputs sampled at the most recent rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| srcVec | input | 256 | Eight packed single-precision source elements |
| vlSel | input | 2 | Vector length select (0:128, 1:256, 2 or 3:512) |
| laneMask | input | 8 | Per-lane writemask |
| maskEn | input | 1 | 1 applies `laneMask`, 0 treats every lane as active |
| zeroMode | input | 1 | 1 zeroes masked-off lanes, 0 merges from `priorDst` |
| bcastEn | input | 1 | Broadcast source element 0 to all lanes |
| priorDst | input | 512 | Prior destination value used for merging |
| resvField | input | 4 | Reserved specifier, must be 4'b1111 |
| resultVec | output | 512 | Eight packed signed 64-bit results |
| invalidFlag | output | 1 | Some active lane was not representable |
| precisionFlag | output | 1 | Some active lane dropped fraction bits |
| undefFlag | output | 1 | Reserved specifier was not all ones |

## Verification
A fault in the lane control decode shows up one clock after the inputs, as a wrong lane in `resultVec`. Depending on the fault, that lane holds a merged prior value where a conversion belongs, a conversion leaking above the vector length, or a zeroed lane under merging. Each lane is compared separately, so the fault is caught on the first operation that uses that mask or length. A fault in the per-lane converter shows as a wrong integer or a wrong flag. The random values are concentrated around the exponent boundaries where the shift direction changes and where the 2^63 limit lies, so such faults also appear within a few operations.

// File: rtl/f2qPkg.sv
package f2qPkg;
  localparam int NUM_LANES = 8;
  localparam int FP_W      = 32;
  localparam int INT_W     = 64;
  localparam int EXP_W     = 8;
  localparam int MAN_W     = 23;
  localparam int BIAS      = 127;
  // Biased exponent at which the magnitude reaches 2^(INT_W-1).
  localparam int EXP_LIMIT = BIAS + INT_W - 1;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  typedef struct packed {
    logic [NUM_LANES-1:0] laneWrite; // lane takes converted value
    logic [NUM_LANES-1:0] laneKeep;  // lane takes prior destination
    logic                 bcast;     // all lanes read element 0
    logic                 undef;     // reserved field malformed
  } ctlStrobes_t;
endpackage

// File: rtl/f2qLaneCvt.sv
module f2qLaneCvt
  import f2qPkg::*;
(
  input  logic [FP_W-1:0]  fpIn,
  output logic [INT_W-1:0] intOut,
  output logic             invalid,
  output logic             inexact
);
  localparam int SH_W = $clog2(INT_W);

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic [INT_W-1:0] wide;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] lost;
  logic [SH_W-1:0]  shR;
  logic [SH_W-1:0]  shL;

  assign sgn  = fpIn[FP_W-1];
  assign expo = fpIn[FP_W-2 -: EXP_W];
  assign man  = fpIn[MAN_W-1:0];
  // Significand aligned to the top of a 64-bit word.
  assign wide = {1'b1, man, {(INT_W-MAN_W-1){1'b0}}};

  always_comb begin
    intOut  = '0;
    invalid = 1'b0;
    inexact = 1'b0;
    mag     = '0;
    lost    = '0;
    shR     = '0;
    shL     = '0;
    if (expo == {EXP_W{1'b1}}) begin
      intOut  = INDEF;
      invalid = 1'b1;
    end else if (expo < EXP_W'(BIAS)) begin
      // |x| < 1: zero, denormal or pure fraction.
      inexact = (expo != '0) || (man != '0);
    end else if (expo >= EXP_W'(EXP_LIMIT)) begin
      intOut  = INDEF;
      invalid = !(sgn && expo == EXP_W'(EXP_LIMIT) && man == '0);
    end else begin
      shR     = SH_W'(EXP_W'(EXP_LIMIT) - expo);
      shL     = SH_W'(expo - EXP_W'(BIAS - 1));
      mag     = wide >> shR;
      lost    = wide << shL;
      inexact = |lost;
      intOut  = sgn ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/f2qCtrl.sv
module f2qCtrl
  import f2qPkg::*;
(
  input  logic [1:0]           vlSel,
  input  logic [NUM_LANES-1:0] laneMask,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic                 bcastEn,
  input  logic [3:0]           resvField,
  output ctlStrobes_t          strobes
);
  localparam int CNT_W = $clog2(NUM_LANES + 1);

  logic [CNT_W-1:0] laneLimit;

  always_comb begin
    case (vlSel)
      2'd0:    laneLimit = CNT_W'(2);
      2'd1:    laneLimit = CNT_W'(4);
      default: laneLimit = CNT_W'(8);
    endcase
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic inRange;
    logic active;
    assign inRange = CNT_W'(j) < laneLimit;
    assign active  = inRange && (!maskEn || laneMask[j]);
    assign strobes.laneWrite[j] = active;
    assign strobes.laneKeep[j]  = inRange && !active && !zeroMode;
  end

  assign strobes.bcast = bcastEn;
  assign strobes.undef = resvField != 4'b1111;
endmodule

// File: rtl/f2qDatapath.sv
module f2qDatapath
  import f2qPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LANES*FP_W-1:0]     srcVec,
  input  logic [NUM_LANES*INT_W-1:0]    priorDst,
  input  ctlStrobes_t                   strobes,
  output logic [NUM_LANES*INT_W-1:0]    resultVec,
  output logic                          invalidFlag,
  output logic                          precisionFlag,
  output logic                          undefFlag
);
  logic [NUM_LANES*INT_W-1:0] nextVec;
  logic [NUM_LANES-1:0]       invVec;
  logic [NUM_LANES-1:0]       precVec;

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic [FP_W-1:0]  laneSrc;
    logic [INT_W-1:0] laneInt;
    logic             laneInv;
    logic             laneInx;

    assign laneSrc = strobes.bcast ? srcVec[FP_W-1:0] : srcVec[j*FP_W +: FP_W];

    f2qLaneCvt cvt_i (
      .fpIn   (laneSrc),
      .intOut (laneInt),
      .invalid(laneInv),
      .inexact(laneInx)
    );

    always_comb begin
      if (strobes.laneWrite[j])     nextVec[j*INT_W +: INT_W] = laneInt;
      else if (strobes.laneKeep[j]) nextVec[j*INT_W +: INT_W] = priorDst[j*INT_W +: INT_W];
      else                          nextVec[j*INT_W +: INT_W] = '0;
    end

    assign invVec[j]  = strobes.laneWrite[j] && laneInv;
    assign precVec[j] = strobes.laneWrite[j] && laneInx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultVec     <= '0;
      invalidFlag   <= 1'b0;
      precisionFlag <= 1'b0;
      undefFlag     <= 1'b0;
    end else begin
      resultVec     <= nextVec;
      invalidFlag   <= |invVec;
      precisionFlag <= |precVec;
      undefFlag     <= strobes.undef;
    end
  end
endmodule

// File: rtl/f2qConvTop.sv
module f2qConvTop
  import f2qPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LANES*FP_W-1:0]  srcVec,
  input  logic [1:0]                 vlSel,
  input  logic [NUM_LANES-1:0]       laneMask,
  input  logic                       maskEn,
  input  logic                       zeroMode,
  input  logic                       bcastEn,
  input  logic [NUM_LANES*INT_W-1:0] priorDst,
  input  logic [3:0]                 resvField,
  output logic [NUM_LANES*INT_W-1:0] resultVec,
  output logic                       invalidFlag,
  output logic                       precisionFlag,
  output logic                       undefFlag
);
  ctlStrobes_t strobes;

  f2qCtrl ctrl_i (
    .vlSel    (vlSel),
    .laneMask (laneMask),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .bcastEn  (bcastEn),
    .resvField(resvField),
    .strobes  (strobes)
  );

  f2qDatapath dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .srcVec       (srcVec),
    .priorDst     (priorDst),
    .strobes      (strobes),
    .resultVec    (resultVec),
    .invalidFlag  (invalidFlag),
    .precisionFlag(precisionFlag),
    .undefFlag    (undefFlag)
  );
endmodule

// File: rtl/f2qConvChecker.sv
module f2qConvChecker (
  input logic         clk,
  input logic         rstN,
  input logic [255:0] srcVec,
  input logic [1:0]   vlSel,
  input logic [7:0]   laneMask,
  input logic         maskEn,
  input logic         zeroMode,
  input logic         bcastEn,
  input logic [511:0] priorDst,
  input logic [3:0]   resvField,
  input logic [511:0] resultVec,
  input logic         invalidFlag,
  input logic         precisionFlag,
  input logic         undefFlag
);
  logic primed;
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(!rstN) |-> (resultVec == '0 && !invalidFlag && !precisionFlag && !undefFlag)); // R12

  AST_UPPER_ZERO_128: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(vlSel) == 2'd0) |-> resultVec[511:128] == '0); // R7

  AST_UPPER_ZERO_256: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(vlSel) == 2'd1) |-> resultVec[511:256] == '0); // R7

  AST_UNDEF_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (undefFlag == ($past(resvField) != 4'b1111))); // R9

  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(maskEn) && !$past(laneMask[0]) && !$past(zeroMode))
      |-> resultVec[63:0] == $past(priorDst[63:0])); // R4

  AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(maskEn) && !$past(laneMask[0]) && $past(zeroMode))
      |-> resultVec[63:0] == '0); // R5

  AST_NO_FLAGS_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(maskEn) && $past(laneMask) == '0)
      |-> (!invalidFlag && !precisionFlag)); // R10

  AST_BCAST_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(bcastEn) && !$past(maskEn) && $past(vlSel) == 2'd1)
      |-> (resultVec[127:64] == resultVec[63:0] && resultVec[255:192] == resultVec[63:0])); // R6

  AST_NAN_INDEF: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(maskEn) && !$past(bcastEn) && $past(srcVec[30:23]) == 8'hFF)
      |-> (resultVec[63:0] == 64'h8000_0000_0000_0000 && invalidFlag)); // R8

  // Unused here but part of the observed interface.
  logic unusedSig;
  assign unusedSig = ^srcVec[255:31];
endmodule

bind f2qConvTop f2qConvChecker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .srcVec       (srcVec),
  .vlSel        (vlSel),
  .laneMask     (laneMask),
  .maskEn       (maskEn),
  .zeroMode     (zeroMode),
  .bcastEn      (bcastEn),
  .priorDst     (priorDst),
  .resvField    (resvField),
  .resultVec    (resultVec),
  .invalidFlag  (invalidFlag),
  .precisionFlag(precisionFlag),
  .undefFlag    (undefFlag)
);

// File: tb/f2qConvTop_tb_top.sv
module f2qConvTop_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic [255:0] srcVec;
  logic [1:0]   vlSel;
  logic [7:0]   laneMask;
  logic         maskEn;
  logic         zeroMode;
  logic         bcastEn;
  logic [511:0] priorDst;
  logic [3:0]   resvField;
  logic [511:0] resultVec;
  logic         invalidFlag;
  logic         precisionFlag;
  logic         undefFlag;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f2qConvTop dut_i (
    .clk(clk), .rstN(rstN), .srcVec(srcVec), .vlSel(vlSel), .laneMask(laneMask),
    .maskEn(maskEn), .zeroMode(zeroMode), .bcastEn(bcastEn), .priorDst(priorDst),
    .resvField(resvField), .resultVec(resultVec), .invalidFlag(invalidFlag),
    .precisionFlag(precisionFlag), .undefFlag(undefFlag)
  );

  // Reference conversion (R1, R8, R11), built from the numeric definition.
  function automatic void refCvt(input logic [31:0] f, output logic [63:0] r,
                                 output bit inv, output bit inx);
    int ue;
    logic [63:0] mag;
    logic [63:0] fracMask;
    ue  = int'(f[30:23]) - 127;
    r   = 64'd0;
    inv = 1'b0;
    inx = 1'b0;
    if (f[30:23] == 8'hFF) begin
      r = 64'h8000_0000_0000_0000; inv = 1'b1;
    end else if (f[30:23] == 8'd0) begin
      inx = (f[22:0] != 0);
    end else if (ue < 0) begin
      inx = 1'b1;
    end else if (ue >= 63) begin
      r   = 64'h8000_0000_0000_0000;
      inv = !(f[31] && ue == 63 && f[22:0] == 0);
    end else begin
      mag = {40'd0, 1'b1, f[22:0]};
      if (ue >= 23) mag = mag << (ue - 23);
      else begin
        fracMask = (64'd1 << (23 - ue)) - 64'd1;
        inx = (mag & fracMask) != 0;
        mag = mag >> (23 - ue);
      end
      r = f[31] ? (64'd0 - mag) : mag;
    end
  endfunction

  function automatic void refVec(output logic [511:0] r, output bit inv, output bit inx);
    int lim;
    logic [63:0] lr;
    bit li, lx;
    lim = (vlSel == 2'd0) ? 2 : (vlSel == 2'd1) ? 4 : 8;
    r = '0; inv = 0; inx = 0;
    for (int j = 0; j < 8; j++) begin
      if (j < lim) begin
        if (!maskEn || laneMask[j]) begin
          refCvt(bcastEn ? srcVec[31:0] : srcVec[j*32 +: 32], lr, li, lx);
          r[j*64 +: 64] = lr;
          inv = inv | li;
          inx = inx | lx;
        end else if (!zeroMode) begin
          r[j*64 +: 64] = priorDst[j*64 +: 64];
        end
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] randFloat();
    logic [7:0] e;
    int kind;
    kind = int'($urandom % 16);
    case (kind)
      0:       e = 8'hFF;
      1:       e = 8'h00;
      2, 3:    e = 8'd188 + 8'($urandom % 4);
      default: e = 8'd110 + 8'($urandom % 85);
    endcase
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  // Drive at a falling edge, compare at the next falling edge.
  task automatic runOp(input string tag);
    logic [511:0] expR;
    bit expI, expX, expU;
    refVec(expR, expI, expX);
    expU = (resvField != 4'b1111);
    @(negedge clk);
    check(resultVec === expR, {tag, " R2 R3 R7 result"}, resultVec, expR);
    check(invalidFlag === expI, {tag, " R8 R10 invalid"}, 512'(invalidFlag), 512'(expI));
    check(precisionFlag === expX, {tag, " R1 R10 precision"}, 512'(precisionFlag), 512'(expX));
    check(undefFlag === expU, {tag, " R9 undef"}, 512'(undefFlag), 512'(expU));
  endtask

  task automatic setOp(input logic [255:0] s, input logic [1:0] vl, input logic [7:0] m,
                       input logic me, input logic zm, input logic bc,
                       input logic [511:0] pd, input logic [3:0] rf);
    srcVec = s; vlSel = vl; laneMask = m; maskEn = me; zeroMode = zm;
    bcastEn = bc; priorDst = pd; resvField = rf;
  endtask

  logic [255:0] dirA;
  logic [255:0] dirB;
  logic [511:0] priorPat;

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0;
    setOp('1, 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, '1, 4'h0);
    repeat (3) @(negedge clk);
    // R12: reset state
    check(resultVec === '0 && !invalidFlag && !precisionFlag && !undefFlag,
          "R12 reset state", resultVec, '0);
    rstN = 1'b1;

    // 1.5, -2.75, -2^63, max below 2^63, min denormal, -0, 0.5, 2^24+2
    dirA = {32'h4B800001, 32'h3F000000, 32'h80000000, 32'h00000001,
            32'h5EFFFFFF, 32'hDF000000, 32'hC0300000, 32'h3FC00000};
    // 2^63, NaN, +inf, -inf, 3.0, -1.0, 1.0, 0
    dirB = {32'h00000000, 32'h3F800000, 32'hBF800000, 32'h40400000,
            32'hFF800000, 32'h7F800000, 32'h7FC00000, 32'h5F000000};
    priorPat = {8{64'hA5A5_0000_1234_5678}};

    setOp(dirA, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("directed finite");
    check(resultVec[63:0] === 64'd1, "R1 1.5 truncates to 1", resultVec[63:0], 64'd1);
    check(resultVec[127:64] === 64'hFFFF_FFFF_FFFF_FFFE, "R1 -2.75 truncates to -2",
          resultVec[127:64], 64'hFFFF_FFFF_FFFF_FFFE);
    check(resultVec[191:128] === 64'h8000_0000_0000_0000 && !invalidFlag,
          "R8 -2^63 converts without invalid", resultVec[191:128], 64'h8000_0000_0000_0000);
    check(resultVec[319:256] === 64'd0 && resultVec[383:320] === 64'd0,
          "R11 denormal and -0 give zero", resultVec[383:256], '0);

    setOp(dirB, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("directed specials");
    check(resultVec[63:0] === 64'h8000_0000_0000_0000 && invalidFlag,
          "R8 2^63 gives indefinite", resultVec[63:0], 64'h8000_0000_0000_0000);

    // R11: -0 alone raises nothing; denormal alone raises precision
    setOp({8{32'h80000000}}, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R11 signed zero");
    setOp({8{32'h00000003}}, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R11 denormal");

    // R4 R5 masking, R10 flags from masked-off specials ignored
    setOp(dirB, 2'd2, 8'hF0, 1'b1, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R4 merge mask");
    setOp(dirB, 2'd2, 8'hF0, 1'b1, 1'b1, 1'b0, priorPat, 4'hF);
    runOp("R5 zero mask");
    setOp(dirA, 2'd1, 8'h00, 1'b1, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R10 all masked");
    // R7 specials above vector length raise nothing
    setOp({dirB[127:0], dirA[127:0]}, 2'd1, 8'hFF, 1'b0, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R7 R10 vl256 upper specials");
    setOp(dirA, 2'd0, 8'hFF, 1'b1, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R7 vl128 merge");
    setOp(dirA, 2'd3, 8'h5A, 1'b1, 1'b0, 1'b0, priorPat, 4'hF);
    runOp("R2 vlSel3");
    // R6 broadcast
    setOp(dirA, 2'd2, 8'hFF, 1'b0, 1'b0, 1'b1, priorPat, 4'hF);
    runOp("R6 broadcast");
    check(resultVec[511:448] === 64'd1, "R6 top lane gets element 0", resultVec[511:448], 64'd1);
    // R9 malformed reserved field
    setOp(dirA, 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, priorPat, 4'hE);
    runOp("R9 reserved 1110");

    for (int n = 0; n < 400; n++) begin
      logic [255:0] s;
      logic [511:0] pd;
      for (int j = 0; j < 8; j++) s[j*32 +: 32] = randFloat();
      for (int j = 0; j < 16; j++) pd[j*32 +: 32] = $urandom;
      setOp(s, 2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 5) == 0, pd, (($urandom % 8) == 0) ? 4'($urandom) : 4'hF);
      runOp("random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule